// File: doc/BRIEF.md
# Ordered Key-Sequence Access Gate

This block guards a protected information region behind a write-only register. Software unlocks the region by writing three fixed 32-bit key words to the register, back to back and in a set order. After the third word lands, the block raises an access-granted output, which neighbouring logic uses to permit reads and writes of the protected region. While access is granted, any write to the register withdraws the grant. No separate lock key is needed.

The block sees one bus write strobe qualified by an address-select input, plus the write data. A bus write with the select low is traffic for another address and leaves the sequence unchanged. A wrong word at any step returns the tracker to idle. If that wrong word happens to be the first key, it counts as the start of a new sequence. Reads of the register always return zero, whatever state the tracker is in.

Top module: `key_unlock_gate`

## Requirements
- R1: After reset is asserted (rst_n low), grant_o is 0 and the tracker is idle, so a first-key, second-key, third-key run is needed to grant.
- R2: Writing 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 on consecutive selected writes sets grant_o to 1 on the clock edge that takes the third write. Idle cycles between the selected writes are allowed.
- R3: A selected write whose data is not the key expected at that step returns the tracker to idle and leaves grant_o at 0.
- R4: A wrong word equal to 0x3A7F5CA3 counts as step one, so a following 0xA1E34F20 then 0x9608B2C1 grants.
- R5: While grant_o is 1, a selected write of any value, key words included, clears grant_o on that clock edge and leaves the tracker idle.
- R6: rdata_o is 0 in every cycle, whether the tracker is idle, mid-sequence or granted.
- R7: A write with sel_i low changes neither grant_o nor the sequence step.
- R8: The second key is accepted only directly after the first, and the third only directly after the second. Out-of-order keys do not grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus access targets this register |
| wr_i | input | 1 | Bus write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, always zero |
| grant_o | output | 1 | Access to the protected region granted |

## Verification
The main path is tried with a clean in-order run, and again with idle gaps between the keys. This shows that only order counts, not adjacency in time. Runs broken by a random word, by the keys in the wrong order and by a repeated first key check that a restart lands in step one and not in idle. Writes with the select low sit in the middle of a run to show they are invisible. While access is granted, both a junk word and the first key are written, to show that any write revokes access.

// File: rtl/key_unlock_pkg.sv
package key_unlock_pkg;
  localparam int unsigned KEY_W = 32;
  localparam logic [KEY_W-1:0] KEY_A = 32'h3A7F5CA3;
  localparam logic [KEY_W-1:0] KEY_B = 32'hA1E34F20;
  localparam logic [KEY_W-1:0] KEY_C = 32'h9608B2C1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GOT_A = 2'd1,
    ST_GOT_B = 2'd2,
    ST_OPEN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/key_match.sv
module key_match
  import key_unlock_pkg::*;
#(
  parameter int unsigned DW = KEY_W
) (
  input  logic [DW-1:0] data_i,
  output logic          is_a_o,
  output logic          is_b_o,
  output logic          is_c_o
);
  always_comb begin
    is_a_o = (data_i == DW'(KEY_A));
    is_b_o = (data_i == DW'(KEY_B));
    is_c_o = (data_i == DW'(KEY_C));
  end
endmodule

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
  import key_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic       is_a_i,
  input  logic       is_b_i,
  input  logic       is_c_i,
  output seq_state_t state_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en_i) begin
      unique case (state_q)
        ST_IDLE:  state_d = is_a_i ? ST_GOT_A : ST_IDLE;
        ST_GOT_A: state_d = is_b_i ? ST_GOT_B : (is_a_i ? ST_GOT_A : ST_IDLE);
        ST_GOT_B: state_d = is_c_i ? ST_OPEN  : (is_a_i ? ST_GOT_A : ST_IDLE);
        ST_OPEN:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else if (wr_en_i) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/key_unlock_gate.sv
module key_unlock_gate
  import key_unlock_pkg::*;
#(
  parameter int unsigned DATA_W = KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              grant_o
);
  logic       wr_en;
  logic       is_a, is_b, is_c;
  seq_state_t state;

  assign wr_en = sel_i & wr_i;

  key_match #(.DW(DATA_W)) u_match (
    .data_i (wdata_i),
    .is_a_o (is_a),
    .is_b_o (is_b),
    .is_c_o (is_c)
  );

  key_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .is_a_i  (is_a),
    .is_b_i  (is_b),
    .is_c_i  (is_c),
    .state_o (state)
  );

  assign grant_o = (state == ST_OPEN);
  assign rdata_o = '0;
endmodule

// File: rtl/key_unlock_gate_chk.sv
module key_unlock_gate_chk
  import key_unlock_pkg::*;
#(
  parameter int unsigned DATA_W = KEY_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              grant_o
);
  a_r6_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o == '0);

  a_r7_no_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_i && wr_i) |=> $stable(grant_o));

  a_r5_any_write_revokes: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && sel_i && wr_i) |=> !grant_o);

  a_r2_grant_on_third: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> ($past(sel_i && wr_i) && $past(wdata_i) == DATA_W'(KEY_C)));

  a_r3_wrong_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && wdata_i != DATA_W'(KEY_C)) |=> !grant_o);
endmodule

bind key_unlock_gate key_unlock_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .grant_o (grant_o)
);

// File: tb/sim_key_unlock_gate.sv
module sim_key_unlock_gate;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] KA = 32'h3A7F5CA3;
  localparam logic [31:0] KB = 32'hA1E34F20;
  localparam logic [31:0] KC = 32'h9608B2C1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_i = 1'b0;
  logic wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic grant_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_unlock_gate u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .grant_o(grant_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on negedge; the edge in the middle captures; sample on the next negedge
  task automatic bus_wr(input logic s, input logic [31:0] d);
    sel_i = s; wr_i = 1'b1; wdata_i = d;
    @(negedge clk);
    sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    check("R1", {31'b0, grant_o}, 32'd0);
    check("R6", rdata_o, 32'd0);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_basic();
    bus_wr(1, KA); check("R6", rdata_o, 0); check("R2", {31'b0, grant_o}, 0);
    bus_wr(1, KB); check("R2", {31'b0, grant_o}, 0);
    bus_wr(1, KC); check("R2", {31'b0, grant_o}, 1);
    check("R6", rdata_o, 0);
    bus_wr(1, 32'h1234_5678); check("R5", {31'b0, grant_o}, 0);
  endtask

  task automatic t_gaps();
    bus_wr(1, KA); idle(3); bus_wr(1, KB); idle(2); bus_wr(1, KC);
    check("R2", {31'b0, grant_o}, 1);
    bus_wr(1, KA); check("R5", {31'b0, grant_o}, 0);
    // tracker is idle after revoke: B then C must not grant
    bus_wr(1, KB); bus_wr(1, KC); check("R5", {31'b0, grant_o}, 0);
  endtask

  task automatic t_wrong();
    bus_wr(1, KA); bus_wr(1, 32'hDEAD_BEEF); bus_wr(1, KB); bus_wr(1, KC);
    check("R3", {31'b0, grant_o}, 0);
    bus_wr(1, KA); bus_wr(1, KB); bus_wr(1, 32'h0); bus_wr(1, KC);
    check("R3", {31'b0, grant_o}, 0);
  endtask

  task automatic t_restart();
    bus_wr(1, KA); bus_wr(1, KA); bus_wr(1, KB); bus_wr(1, KC);
    check("R4", {31'b0, grant_o}, 1);
    bus_wr(1, 0);
    bus_wr(1, KA); bus_wr(1, KB); bus_wr(1, KA); bus_wr(1, KB); bus_wr(1, KC);
    check("R4", {31'b0, grant_o}, 1);
    bus_wr(1, 0);
  endtask

  task automatic t_order();
    bus_wr(1, KB); bus_wr(1, KA); bus_wr(1, KC);
    check("R8", {31'b0, grant_o}, 0);
    bus_wr(1, KC); bus_wr(1, KB); bus_wr(1, KA);
    check("R8", {31'b0, grant_o}, 0);
  endtask

  task automatic t_nosel();
    bus_wr(1, 0);
    bus_wr(1, KA); bus_wr(0, 32'hFFFF_FFFF); bus_wr(1, KB);
    bus_wr(0, KA); bus_wr(1, KC);
    check("R7", {31'b0, grant_o}, 1);
    bus_wr(0, 32'h5); check("R7", {31'b0, grant_o}, 1);
    bus_wr(1, 32'h5); check("R5", {31'b0, grant_o}, 0);
    bus_wr(0, KA); bus_wr(0, KB); bus_wr(0, KC);
    check("R7", {31'b0, grant_o}, 0);
  endtask

  task automatic t_reset_mid();
    bus_wr(1, KA); bus_wr(1, KB);
    do_reset();
    bus_wr(1, KC); check("R1", {31'b0, grant_o}, 0);
    bus_wr(1, KA); bus_wr(1, KB); bus_wr(1, KC);
    do_reset();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_basic();
    t_gaps();
    t_wrong();
    t_restart();
    t_order();
    t_nosel();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule